// File: doc/BRIEF.md
# External Interrupt Detect, Mask and Select

This block turns two active-low external interrupt pins and one serial-port request into a single interrupt request for a processor core. Each external pin first passes through a two-flop synchronizer. A per-pin type bit then chooses how the pin is sensed. In falling-edge mode, a high-to-low transition sets a sticky request flag, and the core clears that flag with an acknowledge strobe. In low-level mode, the request simply follows the synchronized pin.

The serial port raises a sticky flag by pulsing its request input, and the core clears that flag with its own acknowledge strobe. An 8-bit enable register masks each source individually and also holds one global enable bit that sits above all per-source bits. The block presents one registered interrupt line and a 2-bit code naming the highest-priority enabled pending source. The type register and the enable register are written through plain write-enable/data ports.

Top module: `xint_ctrl`

## Requirements
- R1: After reset the interrupt line is low and the source code reads 3 (none). Both type bits are 0 (low-level mode) and the enable register is 00h, so every source is disabled.
- R2: With a pin's type bit at 0 (type bit 0 = ext0, bit 1 = ext1), the pin's request follows its synchronized level: pending while the pin is low, gone once it is high again.
- R3: In low-level mode, the acknowledge strobe for that pin (ack bit 0 = ext0, bit 1 = ext1) has no effect on its request.
- R4: With a type bit at 1, a falling edge (previous synchronized sample 1, current sample 0) latches a request that stays pending after the pin returns high.
- R5: An acknowledge strobe clears a latched edge request. A pin that stays low after the acknowledge does not set the request again. A new edge in the same cycle as an acknowledge wins.
- R6: Writing a type bit to 0 discards any edge request latched for that pin.
- R7: A one-cycle pulse on the serial request input sets a serial flag. The flag holds until ack bit 2 is pulsed.
- R8: Enable register bit 0 allows ext0, bit 1 allows ext1 and bit 2 allows the serial port; a 0 blocks that source. Bits 6:3 are reserved and must be written as 0. A request blocked by its bit stays pending and reaches the output once the bit is set.
- R9: Enable bit 7 is a global enable. While it is 0 the interrupt line stays low whatever the per-source bits hold.
- R10: Among enabled pending sources, priority is ext0 (code 0), then ext1 (code 1), then serial (code 2). The code reads 3 whenever the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n_i | input | 2 | Raw active-low external interrupt pins (bit 0 = ext0) |
| ser_req_i | input | 1 | Serial-port request pulse |
| ack_i | input | 3 | Per-source acknowledge strobes (0 = ext0, 1 = ext1, 2 = serial) |
| mode_we_i | input | 1 | Type register write enable |
| mode_wdata_i | input | 2 | Type bits, 1 = falling edge, 0 = low level |
| en_we_i | input | 1 | Enable register write enable |
| en_wdata_i | input | 8 | Enable register data |
| irq_o | output | 1 | Masked interrupt request (registered) |
| irq_id_o | output | 2 | Code of the selected source, 3 when none |

## Verification
Several states can only be reached through the pin sequencing, and those are the hardest to bring about.

- **Edge latched while masked.** The stimulus masks ext0, pulses the pin low for a few cycles and lets it go high again. The flag must survive with the source masked, and it should appear only when the enable bit is later written.
- **Acknowledge with the pin still low.** The stimulus holds a pin low in edge mode and acknowledges it. The request must not re-arm, because no new high-to-low transition occurs.
- **Switching modes.** The stimulus latches an edge and then flips that pin to level mode while the pin is high. The latched request must be dropped.

A scoreboard queue holds the expected line and code for each settled state.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int N_EXT   = 2;
  localparam int N_SRC   = N_EXT + 1;
  localparam int EN_W    = 8;
  localparam int GLB_BIT = EN_W - 1;
  localparam int ID_W    = 2;

  typedef enum logic [ID_W-1:0] {
    SRC_X0   = 2'd0,
    SRC_X1   = 2'd1,
    SRC_SER  = 2'd2,
    SRC_NONE = 2'd3
  } src_id_e;

  // next value of an edge-mode request flag; a fresh edge beats an acknowledge
  function automatic logic edge_flag_next(input logic edge_mode, input logic fall,
                                          input logic flag, input logic ack);
    return edge_mode ? (fall | (flag & ~ack)) : 1'b0;
  endfunction

  // lowest index among set bits wins; all zero gives SRC_NONE
  function automatic logic [ID_W-1:0] pick_first(input logic [N_SRC-1:0] vec);
    logic [ID_W-1:0] id;
    id = SRC_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vec[i]) id = ID_W'(i);
    end
    return id;
  endfunction
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,    // synchronized, active low
  input  logic edge_mode_i,
  input  logic ack_i,
  output logic req_o,
  output logic fall_o
);
  logic prev_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      flag_q <= edge_flag_next(edge_mode_i, fall_o, flag_q, ack_i);
    end
  end

  assign fall_o = prev_q & ~pin_s_i;
  assign req_o  = edge_mode_i ? flag_q : ~pin_s_i;

  // R4
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && fall_o) |=> flag_q);

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && flag_q && !ack_i) |=> flag_q);

  // R6
  level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode_i |=> !flag_q);
endmodule

// File: rtl/xint_mask_arb.sv
module xint_mask_arb
  import xint_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   pend_i,
  input  logic [N_SRC-1:0]   en_src_i,
  input  logic               en_glb_i,
  output logic               irq_o,
  output logic [ID_W-1:0]    irq_id_o
);
  logic [N_SRC-1:0] masked;
  logic [ID_W-1:0]  pick;

  for (genvar i = 0; i < N_SRC; i++) begin : g_mask
    assign masked[i] = pend_i[i] & en_src_i[i] & en_glb_i;
  end

  assign pick = pick_first(masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      irq_id_o <= SRC_NONE;
    end else begin
      irq_o    <= |masked;
      irq_id_o <= pick;
    end
  end

  // R9
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_glb_i));

  // R10
  id_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (irq_id_o != SRC_NONE));

  // R10
  prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_id_o != SRC_X0) |-> !$past(masked[0]));
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_n_i,
  input  logic             ser_req_i,
  input  logic [2:0]       ack_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_wdata_i,
  input  logic             en_we_i,
  input  logic [7:0]       en_wdata_i,
  output logic             irq_o,
  output logic [1:0]       irq_id_o
);
  logic [N_EXT-1:0] mode_q;
  logic [N_SRC-1:0] en_src_q;
  logic             en_glb_q;
  logic             ser_flag_q;
  logic [N_EXT-1:0] pin_s;
  logic [N_EXT-1:0] ext_req;
  logic [N_EXT-1:0] ext_fall;
  logic [N_SRC-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      en_src_q   <= '0;
      en_glb_q   <= 1'b0;
      ser_flag_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_wdata_i;
      if (en_we_i) begin
        en_src_q <= en_wdata_i[N_SRC-1:0];
        en_glb_q <= en_wdata_i[GLB_BIT];
      end
      ser_flag_q <= edge_flag_next(1'b1, ser_req_i, ser_flag_q, ack_i[N_SRC-1]);
    end
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    xint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_n_i[i]),
      .q_o   (pin_s[i])
    );
    xint_detect u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_s_i     (pin_s[i]),
      .edge_mode_i (mode_q[i]),
      .ack_i       (ack_i[i]),
      .req_o       (ext_req[i]),
      .fall_o      (ext_fall[i])
    );
  end

  assign pend = {ser_flag_q, ext_req};

  xint_mask_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .en_src_i (en_src_q),
    .en_glb_i (en_glb_q),
    .irq_o    (irq_o),
    .irq_id_o (irq_id_o)
  );

  // R7
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_flag_q && !ack_i[N_SRC-1]) |=> ser_flag_q);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |-> (en_wdata_i[GLB_BIT-1:N_SRC] == '0));

  // R4
  fall_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall[0] |-> ($past(pin_s[0]) && !pin_s[0]));
endmodule

// File: tb/xint_ctrl_tb.sv
module xint_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_n = 2'b11;
  logic       ser_req = 1'b0;
  logic [2:0] ack = 3'b000;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wd = 2'b00;
  logic       en_we = 1'b0;
  logic [7:0] en_wd = 8'h00;
  logic       irq;
  logic [1:0] irq_id;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  bit          q_irq[$];
  logic [1:0]  q_id[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  xint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .ser_req_i(ser_req),
    .ack_i(ack), .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .en_we_i(en_we), .en_wdata_i(en_wd), .irq_o(irq), .irq_id_o(irq_id)
  );

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q_tag.size() > 0) begin
        bit         e_irq;
        logic [1:0] e_id;
        string      t;
        e_irq = q_irq.pop_front();
        e_id  = q_id.pop_front();
        t     = q_tag.pop_front();
        n_chk++;
        if (irq !== e_irq || irq_id !== e_id) begin
          n_bad++;
          $display("FAIL %s: irq=%0b id=%0d expected irq=%0b id=%0d", t, irq, irq_id, e_irq, e_id);
        end
      end
    end
  end

  task automatic expect_out(input bit e_irq, input logic [1:0] e_id, input string t);
    q_irq.push_back(e_irq);
    q_id.push_back(e_id);
    q_tag.push_back(t);
    wait (q_tag.size() == 0);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk); en_we = 1'b1; en_wd = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wd = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic pulse_ack(input int i);
    @(negedge clk); ack[i] = 1'b1;
    @(negedge clk); ack[i] = 1'b0;
  endtask

  task automatic pin_pulse(input int i);
    @(negedge clk); ext_n[i] = 1'b0;
    repeat (3) @(negedge clk);
    ext_n[i] = 1'b1;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, cycles=%0d expected below 200000", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_out(1'b0, 2'd3, "R1 reset idle");
    ext_n[0] = 1'b0; settle();
    expect_out(1'b0, 2'd3, "R1 enables clear after reset");

    wr_en(8'h87); settle();
    expect_out(1'b1, 2'd0, "R2 level low pin pending");
    ext_n[0] = 1'b1; settle();
    expect_out(1'b0, 2'd3, "R2 level follows pin high");

    ext_n[1] = 1'b0; settle();
    pulse_ack(1); settle();
    expect_out(1'b1, 2'd1, "R3 ack ignored in level mode");
    ext_n[1] = 1'b1; settle();

    wr_mode(2'b01);
    pin_pulse(0); settle();
    expect_out(1'b1, 2'd0, "R4 edge latched after release");
    pulse_ack(0); settle();
    expect_out(1'b0, 2'd3, "R5 ack clears edge flag");

    ext_n[0] = 1'b0; settle();
    expect_out(1'b1, 2'd0, "R4 edge from held low");
    pulse_ack(0); settle();
    expect_out(1'b0, 2'd3, "R5 no retrigger while held low");
    ext_n[0] = 1'b1; settle();

    @(negedge clk); ser_req = 1'b1;
    @(negedge clk); ser_req = 1'b0;
    wr_mode(2'b00);
    ext_n[1] = 1'b0; settle();
    expect_out(1'b1, 2'd1, "R10 ext1 over serial");
    ext_n[0] = 1'b0; settle();
    expect_out(1'b1, 2'd0, "R10 ext0 over ext1");
    ext_n = 2'b11; settle();
    expect_out(1'b1, 2'd2, "R7 serial flag held");
    pulse_ack(2); settle();
    expect_out(1'b0, 2'd3, "R7 ack clears serial");

    wr_en(8'h07); ext_n[0] = 1'b0; settle();
    expect_out(1'b0, 2'd3, "R9 global bit blocks");
    wr_en(8'h87); settle();
    expect_out(1'b1, 2'd0, "R9 global bit allows");
    wr_en(8'h86); ext_n[1] = 1'b0; settle();
    expect_out(1'b1, 2'd1, "R8 ext0 masked, ext1 shown");
    wr_en(8'h84); settle();
    expect_out(1'b0, 2'd3, "R8 both ext masked");
    ext_n = 2'b11; settle();

    wr_mode(2'b01); wr_en(8'h86);
    pin_pulse(0); settle();
    expect_out(1'b0, 2'd3, "R8 edge latched while masked");
    wr_en(8'h87); settle();
    expect_out(1'b1, 2'd0, "R8 pending shown once enabled");

    wr_mode(2'b10);
    expect_out(1'b0, 2'd3, "R6 ext0 flag dropped on level switch");
    pin_pulse(1); settle();
    expect_out(1'b1, 2'd1, "R4 ext1 edge latched");
    wr_mode(2'b00); settle();
    expect_out(1'b0, 2'd3, "R6 ext1 flag dropped on level switch");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule